// File: doc/BRIEF.md
# Streaming x86 Prefix and Opcode Sequencer

This block accepts instruction bytes one per cycle on a valid/ready byte input and follows one x86-style instruction at a time. It goes through the prefix bytes, the primary opcode, an optional second opcode page reached through 0x0F, a ModR/M byte, an optional scale-index-base byte, and any trailing displacement or immediate bytes. When the last byte of an instruction is taken, the block reports the instruction: its opcode class, the final opcode byte, the number of bytes consumed and the prefix state collected on the way.

Prefix state persists across any number of prefix bytes: segment override, lock and repeat kind, and the operand-size and address-size toggles. A mode input selects 32-bit defaults with a 15-byte length cap, or 16-bit defaults with a 10-byte cap. An opcode outside the supported subset, or an instruction that reaches the cap before it ends, produces a one-cycle undefined pulse. The byte that triggers it is discarded, and all state returns to the start of a new instruction. The supported subset is the eight ALU groups, the one-byte register INC/DEC/PUSH/POP, the short and near conditional jumps, and MOV register,immediate.

Top module: `insn_front_seq`

## Requirements
- R1: While `rst` is high, `in_ready`, `done_valid` and `undef_pulse` are low. After `rst` falls, `in_ready` is high and the block waits for a new instruction with no prefixes.
- R2: Bytes 0x26, 0x2E, 0x36 and 0x3E set `done_seg` to 1, 2, 3 and 4 respectively; 0 means no override. If several are given, the last one wins.
- R3: 0xF0 sets `done_lock`. 0xF3 sets `done_rep` to 1 and 0xF2 sets it to 2; 0 means no repeat. If several repeat bytes are given, the last one wins. These bytes keep the block in the prefix phase.
- R4: With `mode32`=1, 0x66 makes the operand size the opposite of the 32-bit default, and 0x67 does the same for the address size. Repeating either byte leaves the size at the opposite value. With `mode32`=0, the defaults are 16-bit and 0x66 or 0x67 is undefined.
- R5: In the ALU group at base B (B = 0x00, 0x08, …, 0x38), offsets 0 to 3 give class 0 and take a ModR/M byte. With mod=3 there is no displacement. With 16-bit addressing, mod=1 adds 1 byte, mod=2 adds 2 bytes, and mod=0 with rm=6 adds 2 bytes. With 32-bit addressing, mod=1 adds 1 byte, mod=2 adds 4 bytes, and mod=0 with rm=5 adds 4 bytes.
- R6: ALU offset 4 gives class 1 with a 1-byte immediate. Offset 5 gives class 1 with an immediate of the current operand size (2 or 4 bytes).
- R7: 0x40 to 0x5F complete in one byte. Opcode bits [4:3] select the class: 0 gives class 2 (INC), 1 gives class 3 (DEC), 2 gives class 4 (PUSH) and 3 gives class 5 (POP).
- R8: 0x70 to 0x7F give class 6 followed by one displacement byte.
- R9: 0x0F followed by 0x80 to 0x8F gives class 7 with a displacement of the current operand size, and `done_opcode` holds the second byte. Any other second byte is undefined, and with `mode32`=0 the whole page is undefined.
- R10: 0xB0 to 0xB7 give class 8 with a 1-byte immediate. 0xB8 to 0xBF give class 8 with an immediate of the current operand size.
- R11: The length cap is 15 bytes with `mode32`=1 and 10 bytes with `mode32`=0. An instruction that ends exactly at the cap completes. If the byte that brings the count to the cap does not end the instruction, that byte produces an undefined result.
- R12: An unsupported byte produces a one-cycle `undef_pulse` and no `done_valid`. All prefix state is cleared, and the next instruction starts clean.
- R13: `done_valid` is high for exactly the one cycle after the final byte is accepted. `done_len` counts only the bytes that were accepted, prefixes included; idle cycles inside an instruction do not count.
- R14: With 32-bit addressing, rm=4 with mod≠3 takes a scale-index-base byte after the ModR/M byte. If mod=0 and that byte's low three bits are 5, a further 4 displacement bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | 1 = 32-bit defaults and 15-byte cap; 0 = 16-bit defaults and 10-byte cap; change only between instructions |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte is accepted when both valid and ready are high |
| done_valid | output | 1 | One-cycle pulse: instruction decoded |
| done_class | output | 4 | Opcode class code (see R5 to R10) |
| done_opcode | output | 8 | Final opcode byte |
| done_len | output | 4 | Bytes consumed by the instruction |
| done_seg | output | 3 | Segment override code |
| done_lock | output | 1 | Lock prefix seen |
| done_rep | output | 2 | Repeat kind |
| done_opsz32 | output | 1 | Effective operand size is 32-bit |
| done_adsz32 | output | 1 | Effective address size is 32-bit |
| undef_pulse | output | 1 | One-cycle pulse: instruction undefined or over length |

## Verification
The hardest case to reach is the length cap. It only fires after a long run of prefix bytes, and it has to be probed on both sides of the boundary in both modes. The stimulus feeds one prefix byte less than the cap followed by a one-byte opcode, which must complete at the cap. It then feeds a full cap's worth of prefixes, which must turn undefined on the last byte. Addressing forms that lengthen the instruction are reached by combining the size prefixes with chosen ModR/M and scale-index-base values. The bench then confirms that the instruction after an undefined result starts with clean prefixes.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    typedef enum logic [2:0] {
        PH_PREFIX = 3'd0,
        PH_PAGE2  = 3'd1,
        PH_MODRM  = 3'd2,
        PH_SIB    = 3'd3,
        PH_TAIL   = 3'd4
    } phase_e;

    typedef enum logic [3:0] {
        CL_ALU_RM  = 4'd0,
        CL_ALU_ACC = 4'd1,
        CL_INC     = 4'd2,
        CL_DEC     = 4'd3,
        CL_PUSH    = 4'd4,
        CL_POP     = 4'd5,
        CL_JSHORT  = 4'd6,
        CL_JNEAR   = 4'd7,
        CL_MOV_IMM = 4'd8
    } op_class_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        REP_NONE = 2'd0,
        REP_EQ   = 2'd1,
        REP_NE   = 2'd2
    } rep_e;

    typedef struct packed {
        seg_e  seg;
        logic  lock;
        rep_e  rep;
        logic  opsz_flip;
        logic  adsz_flip;
    } pfx_t;

    typedef enum logic [2:0] {
        DK_UNDEF  = 3'd0,
        DK_PREFIX = 3'd1,
        DK_PAGE2  = 3'd2,
        DK_DONE   = 3'd3,
        DK_MODRM  = 3'd4,
        DK_TAIL   = 3'd5
    } dec_kind_e;

    typedef struct packed {
        dec_kind_e  kind;
        op_class_e  cls;
        logic [2:0] tail;
    } dec_t;

    localparam pfx_t PFX_CLEAR = '{SEG_NONE, 1'b0, REP_NONE, 1'b0, 1'b0};

    function automatic logic [2:0] size_bytes(input logic wide);
        return wide ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [2:0] sib_extra(input logic [1:0] mode, input logic [2:0] base);
        return (mode == 2'd0 && base == 3'd5) ? 3'd4 : 3'd0;
    endfunction

endpackage

// File: rtl/ifs_opcode_dec.sv
module ifs_opcode_dec
    import ifs_pkg::*;
(
    input  logic [7:0] op_byte,
    input  logic       second_page,
    input  logic       mode32,
    input  logic       opsz32,
    input  pfx_t       pfx_in,
    output dec_t       dec,
    output pfx_t       pfx_out
);

    always_comb begin
        dec     = '{DK_UNDEF, CL_ALU_RM, 3'd0};
        pfx_out = pfx_in;
        if (second_page) begin
            if (mode32 && op_byte[7:4] == 4'h8)
                dec = '{DK_TAIL, CL_JNEAR, size_bytes(opsz32)};
        end else begin
            casez (op_byte)
                8'h26: begin dec.kind = DK_PREFIX; pfx_out.seg = SEG_ES; end
                8'h2E: begin dec.kind = DK_PREFIX; pfx_out.seg = SEG_CS; end
                8'h36: begin dec.kind = DK_PREFIX; pfx_out.seg = SEG_SS; end
                8'h3E: begin dec.kind = DK_PREFIX; pfx_out.seg = SEG_DS; end
                8'hF0: begin dec.kind = DK_PREFIX; pfx_out.lock = 1'b1; end
                8'hF2: begin dec.kind = DK_PREFIX; pfx_out.rep = REP_NE; end
                8'hF3: begin dec.kind = DK_PREFIX; pfx_out.rep = REP_EQ; end
                8'h66: if (mode32) begin dec.kind = DK_PREFIX; pfx_out.opsz_flip = 1'b1; end
                8'h67: if (mode32) begin dec.kind = DK_PREFIX; pfx_out.adsz_flip = 1'b1; end
                8'h0F: dec.kind = DK_PAGE2;
                8'b00???0??: dec = '{DK_MODRM, CL_ALU_RM, 3'd0};
                8'b00???10?: dec = '{DK_TAIL, CL_ALU_ACC,
                                     op_byte[0] ? size_bytes(opsz32) : 3'd1};
                8'b010?????: begin
                    dec.kind = DK_DONE;
                    case (op_byte[4:3])
                        2'd0:    dec.cls = CL_INC;
                        2'd1:    dec.cls = CL_DEC;
                        2'd2:    dec.cls = CL_PUSH;
                        default: dec.cls = CL_POP;
                    endcase
                end
                8'b0111????: dec = '{DK_TAIL, CL_JSHORT, 3'd1};
                8'b1011????: dec = '{DK_TAIL, CL_MOV_IMM,
                                     op_byte[3] ? size_bytes(opsz32) : 3'd1};
                default: dec.kind = DK_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/ifs_addr_len.sv
module ifs_addr_len (
    input  logic [1:0] mode,
    input  logic [2:0] rm,
    input  logic       adsz32,
    output logic       need_sib,
    output logic [2:0] disp_len
);

    always_comb begin
        need_sib = 1'b0;
        disp_len = 3'd0;
        if (mode != 2'd3) begin
            if (adsz32) begin
                need_sib = (rm == 3'd4);
                case (mode)
                    2'd1:    disp_len = 3'd1;
                    2'd2:    disp_len = 3'd4;
                    default: disp_len = (rm == 3'd5) ? 3'd4 : 3'd0;
                endcase
            end else begin
                case (mode)
                    2'd1:    disp_len = 3'd1;
                    2'd2:    disp_len = 3'd2;
                    default: disp_len = (rm == 3'd6) ? 3'd2 : 3'd0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ifs_len_guard.sv
module ifs_len_guard #(
    parameter int CAP_WIDE   = 15,
    parameter int CAP_NARROW = 10,
    parameter int LEN_W      = 4
) (
    input  logic             mode32,
    input  logic [LEN_W-1:0] count_next,
    output logic             at_cap
);

    localparam logic [LEN_W-1:0] CAP_W = LEN_W'(CAP_WIDE);
    localparam logic [LEN_W-1:0] CAP_N = LEN_W'(CAP_NARROW);

    assign at_cap = (count_next == (mode32 ? CAP_W : CAP_N));

endmodule

// File: rtl/insn_front_seq.sv
module insn_front_seq
    import ifs_pkg::*;
#(
    parameter int CAP_WIDE   = 15,
    parameter int CAP_NARROW = 10,
    localparam int LEN_W     = $clog2(CAP_WIDE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode32,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             done_valid,
    output logic [3:0]       done_class,
    output logic [7:0]       done_opcode,
    output logic [LEN_W-1:0] done_len,
    output logic [2:0]       done_seg,
    output logic             done_lock,
    output logic [1:0]       done_rep,
    output logic             done_opsz32,
    output logic             done_adsz32,
    output logic             undef_pulse
);

    phase_e           phase_q, phase_n;
    logic [LEN_W-1:0] count_q, count_n, count_inc;
    pfx_t             pfx_q, pfx_n, pfx_dec;
    op_class_e        cls_q, cls_n;
    logic [7:0]       opc_q, opc_n;
    logic [3:0]       remain_q, remain_n;
    logic [1:0]       mod_q, mod_n;

    logic             accept, complete, fail, at_cap;
    logic             opsz32, adsz32;
    dec_t             dec;
    logic             need_sib;
    logic [2:0]       disp_len;
    logic [3:0]       sib_total;

    assign in_ready  = ~rst;
    assign accept    = in_valid & in_ready;
    assign count_inc = count_q + 1'b1;
    assign opsz32    = mode32 ^ pfx_q.opsz_flip;
    assign adsz32    = mode32 ^ pfx_q.adsz_flip;
    assign sib_total = remain_q + {1'b0, sib_extra(mod_q, in_byte[2:0])};

    ifs_opcode_dec u_dec (
        .op_byte     (in_byte),
        .second_page (phase_q == PH_PAGE2),
        .mode32      (mode32),
        .opsz32      (opsz32),
        .pfx_in      (pfx_q),
        .dec         (dec),
        .pfx_out     (pfx_dec)
    );

    ifs_addr_len u_addr (
        .mode     (in_byte[7:6]),
        .rm       (in_byte[2:0]),
        .adsz32   (adsz32),
        .need_sib (need_sib),
        .disp_len (disp_len)
    );

    ifs_len_guard #(
        .CAP_WIDE   (CAP_WIDE),
        .CAP_NARROW (CAP_NARROW),
        .LEN_W      (LEN_W)
    ) u_guard (
        .mode32     (mode32),
        .count_next (count_inc),
        .at_cap     (at_cap)
    );

    always_comb begin
        phase_n  = phase_q;
        count_n  = count_q;
        pfx_n    = pfx_q;
        cls_n    = cls_q;
        opc_n    = opc_q;
        remain_n = remain_q;
        mod_n    = mod_q;
        complete = 1'b0;
        fail     = 1'b0;
        if (accept) begin
            count_n = count_inc;
            case (phase_q)
                PH_PREFIX, PH_PAGE2: begin
                    case (dec.kind)
                        DK_PREFIX: pfx_n = pfx_dec;
                        DK_PAGE2:  phase_n = PH_PAGE2;
                        DK_DONE: begin
                            complete = 1'b1;
                            cls_n    = dec.cls;
                            opc_n    = in_byte;
                        end
                        DK_MODRM: begin
                            phase_n = PH_MODRM;
                            cls_n   = dec.cls;
                            opc_n   = in_byte;
                        end
                        DK_TAIL: begin
                            phase_n  = PH_TAIL;
                            cls_n    = dec.cls;
                            opc_n    = in_byte;
                            remain_n = {1'b0, dec.tail};
                        end
                        default: fail = 1'b1;
                    endcase
                end
                PH_MODRM: begin
                    mod_n    = in_byte[7:6];
                    remain_n = {1'b0, disp_len};
                    if (need_sib)
                        phase_n = PH_SIB;
                    else if (disp_len != 3'd0)
                        phase_n = PH_TAIL;
                    else
                        complete = 1'b1;
                end
                PH_SIB: begin
                    remain_n = sib_total;
                    if (sib_total != 4'd0)
                        phase_n = PH_TAIL;
                    else
                        complete = 1'b1;
                end
                PH_TAIL: begin
                    remain_n = remain_q - 4'd1;
                    if (remain_q == 4'd1)
                        complete = 1'b1;
                end
                default: fail = 1'b1;
            endcase
            if (!complete && at_cap)
                fail = 1'b1;
            if (complete || fail) begin
                phase_n  = PH_PREFIX;
                count_n  = '0;
                pfx_n    = PFX_CLEAR;
                remain_n = 4'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_PREFIX;
            count_q     <= '0;
            pfx_q       <= PFX_CLEAR;
            cls_q       <= CL_ALU_RM;
            opc_q       <= 8'h00;
            remain_q    <= 4'd0;
            mod_q       <= 2'd0;
            done_valid  <= 1'b0;
            undef_pulse <= 1'b0;
            done_class  <= 4'd0;
            done_opcode <= 8'h00;
            done_len    <= '0;
            done_seg    <= 3'd0;
            done_lock   <= 1'b0;
            done_rep    <= 2'd0;
            done_opsz32 <= 1'b0;
            done_adsz32 <= 1'b0;
        end else begin
            phase_q     <= phase_n;
            count_q     <= count_n;
            pfx_q       <= pfx_n;
            cls_q       <= cls_n;
            opc_q       <= opc_n;
            remain_q    <= remain_n;
            mod_q       <= mod_n;
            done_valid  <= accept & complete;
            undef_pulse <= accept & fail;
            if (accept & complete) begin
                done_class  <= cls_n;
                done_opcode <= opc_n;
                done_len    <= count_inc;
                done_seg    <= pfx_q.seg;
                done_lock   <= pfx_q.lock;
                done_rep    <= pfx_q.rep;
                done_opsz32 <= opsz32;
                done_adsz32 <= adsz32;
            end
        end
    end

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_valid && undef_pulse)); // R12

    AST_CLEAN_AFTER: assert property (@(posedge clk) disable iff (rst)
        (done_valid || undef_pulse) |-> (count_q == '0 && pfx_q == PFX_CLEAR && phase_q == PH_PREFIX)); // R12

    AST_LEN_WIDE: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_len != '0 && done_len <= LEN_W'(CAP_WIDE))); // R11

    AST_LEN_NARROW: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !$past(mode32)) |-> (done_len <= LEN_W'(CAP_NARROW))); // R11

    AST_NARROW_SIZES: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !$past(mode32)) |-> (!done_opsz32 && !done_adsz32)); // R4

    AST_TAIL_PENDING: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL) |-> (remain_q != 4'd0)); // R13

    AST_SHORT_JUMP_LEN: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_class == 4'd6) |-> (done_len >= LEN_W'(2))); // R8

endmodule

// File: tb/sim_insn_front_seq.sv
module sim_insn_front_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode32;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       in_ready;
    logic       done_valid;
    logic [3:0] done_class;
    logic [7:0] done_opcode;
    logic [3:0] done_len;
    logic [2:0] done_seg;
    logic       done_lock;
    logic [1:0] done_rep;
    logic       done_opsz32;
    logic       done_adsz32;
    logic       undef_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_front_seq u0 (
        .clk (clk), .rst (rst), .mode32 (mode32),
        .in_valid (in_valid), .in_byte (in_byte), .in_ready (in_ready),
        .done_valid (done_valid), .done_class (done_class), .done_opcode (done_opcode),
        .done_len (done_len), .done_seg (done_seg), .done_lock (done_lock),
        .done_rep (done_rep), .done_opsz32 (done_opsz32), .done_adsz32 (done_adsz32),
        .undef_pulse (undef_pulse)
    );

    typedef struct {
        bit         undef;
        logic [3:0] cls;
        logic [7:0] op;
        logic [3:0] len;
        logic [2:0] seg;
        logic       lock;
        logic [1:0] rep;
        logic       o32;
        logic       a32;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   vectors = 0;
    int   errors  = 0;
    bit   finished = 1'b0;

    task automatic expect_ok(input logic [3:0] cls, input logic [7:0] op, input int len,
                             input logic [2:0] seg, input logic lock, input logic [1:0] rep,
                             input logic o32, input logic a32, input string tag);
        exp_t e;
        e.undef = 1'b0; e.cls = cls; e.op = op; e.len = 4'(len); e.seg = seg;
        e.lock = lock; e.rep = rep; e.o32 = o32; e.a32 = a32; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic expect_undef(input string tag);
        exp_t e;
        e = '{1'b1, 4'd0, 8'h00, 4'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, tag};
        sb.push_back(e);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a result pulse appears
    always @(negedge clk) begin
        if (!rst && (done_valid || undef_pulse)) begin
            vectors++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R13 unexpected result actual valid=%0d undef=%0d expected none",
                         done_valid, undef_pulse);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.undef) begin
                    if (!(undef_pulse && !done_valid)) begin
                        errors++;
                        $display("FAIL %s actual valid=%0d undef=%0d expected undef",
                                 e.tag, done_valid, undef_pulse);
                    end
                end else if (!(done_valid && !undef_pulse) || done_class !== e.cls ||
                             done_opcode !== e.op || done_len !== e.len || done_seg !== e.seg ||
                             done_lock !== e.lock || done_rep !== e.rep ||
                             done_opsz32 !== e.o32 || done_adsz32 !== e.a32) begin
                    errors++;
                    $display("FAIL %s actual v=%0d u=%0d cls=%0d op=%h len=%0d seg=%0d lock=%0d rep=%0d o32=%0d a32=%0d expected cls=%0d op=%h len=%0d seg=%0d lock=%0d rep=%0d o32=%0d a32=%0d",
                             e.tag, done_valid, undef_pulse, done_class, done_opcode, done_len,
                             done_seg, done_lock, done_rep, done_opsz32, done_adsz32,
                             e.cls, e.op, e.len, e.seg, e.lock, e.rep, e.o32, e.a32);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode32 = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!in_ready && !done_valid && !undef_pulse, "R1 outputs in reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);

        // ---------------- 32-bit mode ----------------
        expect_ok(4'd2, 8'h40, 1, 3'd0, 0, 2'd0, 1, 1, "R1 R7 INC clean start");
        put(8'h40);
        expect_ok(4'd5, 8'h5B, 1, 3'd0, 0, 2'd0, 1, 1, "R7 POP");
        put(8'h5B);
        expect_ok(4'd4, 8'h50, 4, 3'd1, 1, 2'd1, 1, 1, "R2 R3 ES lock repe");
        put(8'h26); put(8'hF0); put(8'hF3); put(8'h50);
        expect_ok(4'd3, 8'h48, 5, 3'd4, 0, 2'd2, 1, 1, "R2 R3 last prefix wins");
        put(8'h2E); put(8'h3E); put(8'hF3); put(8'hF2); put(8'h48);
        expect_ok(4'd1, 8'h05, 4, 3'd0, 0, 2'd0, 0, 1, "R4 R6 opsize flip imm16");
        put(8'h66); put(8'h05); put(8'h34); put(8'h12);
        expect_ok(4'd1, 8'h2C, 2, 3'd0, 0, 2'd0, 1, 1, "R6 imm8");
        put(8'h2C); put(8'h11);
        expect_ok(4'd1, 8'h3D, 5, 3'd0, 0, 2'd0, 1, 1, "R6 imm32");
        put(8'h3D); put(8'h01); put(8'h02); put(8'h03); put(8'h04);
        expect_ok(4'd0, 8'h01, 2, 3'd0, 0, 2'd0, 1, 1, "R5 mod3");
        put(8'h01); put(8'hC0);
        expect_ok(4'd0, 8'h1B, 3, 3'd0, 0, 2'd0, 1, 1, "R5 mod1 disp8");
        put(8'h1B); put(8'h45); put(8'h7F);
        expect_ok(4'd0, 8'h03, 6, 3'd0, 0, 2'd0, 1, 1, "R5 mod0 rm5 disp32");
        put(8'h03); put(8'h05); put(8'h00); put(8'h00); put(8'h00); put(8'h10);
        expect_ok(4'd0, 8'h03, 5, 3'd0, 0, 2'd0, 1, 0, "R4 R5 addr16 direct");
        put(8'h67); put(8'h03); put(8'h06); put(8'h00); put(8'h20);
        expect_ok(4'd0, 8'h3B, 7, 3'd0, 0, 2'd0, 0, 0, "R4 R5 repeated flips mod2");
        put(8'h67); put(8'h66); put(8'h67); put(8'h3B); put(8'h80); put(8'h01); put(8'h02);
        expect_ok(4'd0, 8'h01, 7, 3'd0, 0, 2'd0, 1, 1, "R14 sib base5 disp32");
        put(8'h01); put(8'h04); put(8'h25); put(8'h1); put(8'h2); put(8'h3); put(8'h4);
        expect_ok(4'd0, 8'h21, 4, 3'd0, 0, 2'd0, 1, 1, "R14 sib mod1");
        put(8'h21); put(8'h44); put(8'h00); put(8'h08);
        expect_ok(4'd6, 8'h75, 2, 3'd0, 0, 2'd0, 1, 1, "R8 short jump");
        put(8'h75); put(8'h10);
        expect_ok(4'd7, 8'h84, 6, 3'd0, 0, 2'd0, 1, 1, "R9 near jump 32");
        put(8'h0F); put(8'h84); put(8'h1); put(8'h2); put(8'h3); put(8'h4);
        expect_ok(4'd7, 8'h8F, 5, 3'd0, 0, 2'd0, 0, 1, "R9 near jump 16 via flip");
        put(8'h66); put(8'h0F); put(8'h8F); put(8'h1); put(8'h2);
        expect_undef("R9 bad second page byte");
        put(8'h0F); put(8'h05);
        expect_ok(4'd8, 8'hB3, 2, 3'd0, 0, 2'd0, 1, 1, "R10 mov imm8");
        put(8'hB3); put(8'h7F);
        expect_ok(4'd8, 8'hB9, 5, 3'd0, 0, 2'd0, 1, 1, "R10 mov imm32");
        put(8'hB9); put(8'h1); put(8'h2); put(8'h3); put(8'h4);
        expect_undef("R12 unsupported opcode");
        put(8'h26); put(8'hF0); put(8'hF4);
        expect_ok(4'd2, 8'h41, 1, 3'd0, 0, 2'd0, 1, 1, "R12 prefixes cleared after undef");
        put(8'h41);
        expect_ok(4'd4, 8'h52, 15, 3'd0, 1, 2'd0, 1, 1, "R11 exactly at cap 15");
        for (int i = 0; i < 14; i++) put(8'hF0);
        put(8'h52);
        expect_undef("R11 cap 15 exceeded");
        for (int i = 0; i < 15; i++) put(8'hF0);
        expect_ok(4'd3, 8'h4F, 1, 3'd0, 0, 2'd0, 1, 1, "R11 R12 clean after cap");
        put(8'h4F);
        expect_ok(4'd6, 8'h70, 2, 3'd0, 0, 2'd0, 1, 1, "R13 idle gaps not counted");
        put(8'h70); idle(3); put(8'h00);
        // R13: pulse exactly one cycle after final byte
        idle(2);
        expect_ok(4'd2, 8'h47, 1, 3'd0, 0, 2'd0, 1, 1, "R13 pulse timing");
        put(8'h47);
        @(negedge clk); in_valid = 1'b0;
        check(done_valid === 1'b1, "R13 done_valid after final byte", int'(done_valid), 1);
        @(negedge clk);
        check(done_valid === 1'b0, "R13 done_valid one cycle", int'(done_valid), 0);

        // ---------------- 16-bit mode ----------------
        idle(2);
        mode32 = 1'b0;
        idle(2);
        expect_ok(4'd2, 8'h40, 1, 3'd0, 0, 2'd0, 0, 0, "R4 16-bit defaults");
        put(8'h40);
        expect_undef("R4 opsize prefix in 16-bit mode");
        put(8'h66);
        expect_undef("R4 addrsize prefix in 16-bit mode");
        put(8'h67);
        expect_undef("R9 second page in 16-bit mode");
        put(8'h0F); put(8'h84);
        expect_ok(4'd0, 8'h01, 4, 3'd0, 0, 2'd0, 0, 0, "R5 16-bit direct");
        put(8'h01); put(8'h06); put(8'h00); put(8'h30);
        expect_ok(4'd0, 8'h03, 2, 3'd0, 0, 2'd0, 0, 0, "R5 R14 16-bit rm4 no sib");
        put(8'h03); put(8'h04);
        expect_ok(4'd8, 8'hB8, 3, 3'd0, 0, 2'd0, 0, 0, "R10 mov imm16");
        put(8'hB8); put(8'h34); put(8'h12);
        expect_ok(4'd1, 8'h15, 3, 3'd0, 0, 2'd0, 0, 0, "R6 imm16 default");
        put(8'h15); put(8'h01); put(8'h02);
        expect_ok(4'd2, 8'h43, 10, 3'd0, 0, 2'd2, 0, 0, "R11 exactly at cap 10");
        for (int i = 0; i < 9; i++) put(8'hF2);
        put(8'h43);
        expect_undef("R11 cap 10 exceeded");
        for (int i = 0; i < 10; i++) put(8'hF3);
        expect_ok(4'd5, 8'h58, 1, 3'd0, 0, 2'd0, 0, 0, "R11 clean after cap 10");
        put(8'h58);

        idle(4);
        check(sb.size() == 0, "R13 all results delivered", sb.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule